// File: doc/BRIEF.md
# Bandwidth slot table builder

This block fills the slot table of a time-slotted memory arbiter. Each entry of the table names the client that owns that slot. A build starts with a one-cycle start pulse. At that moment the block takes a snapshot of the per-client requested slot counts, the per-client active flags and the count of spare slots. It then builds the table in two passes inside a private copy. The first pass gives each requesting client its slots at a fixed stride and skips over slots already taken. The same pass gives each active client with a zero request one spare slot. The second pass hands every still-empty slot to active clients in rotating order. It also streams the whole table out through a write port, one slot per clock.

A small combinational admission stage sits beside the builder. It turns a bandwidth figure into a slot count, using the peak bandwidth of the region as the reference. It also says whether that count still fits next to the slots already granted. The caller keeps the per-client bookkeeping and triggers a rebuild after each admission or release.

Top module: `slot_table_builder`

## Requirements
- R1: Out of reset, `wr_en_o` and `done_o` are both low.
- R2: After an accepted start, the table is written exactly 64 times on consecutive clocks, at slot indexes 0, 1, ..., 63 in that order. `done_o` rises in the cycle after the write of slot 63. It stays high, with `wr_en_o` low, until the next accepted start.
- R3: Clients are placed in ascending index order. A client with request n (1..64) probes from slot 0. An occupied slot moves the probe on by one. A free slot takes the client and moves the probe on by 64/n (integer division). Placement ends once the probe passes slot 63.
- R4: An active client with a zero request takes the first free slot while the spare count latched at start is above zero, and it uses up one spare. Inactive zero-request clients take nothing in this pass, and so do zero-request clients once no spares are left.
- R5: Every slot still empty after placement goes to the next active client at or after a rotating pointer. The pointer starts at 0 for each build, carries from slot to slot, and moves to one past the chosen client after each such assignment, wrapping from 13 to 0.
- R6: When no client is active, each leftover slot takes the pointer value itself. The leftover slots therefore read 0, 1, ..., 13, 0, ... in slot order.
- R7: A start pulse during a build is ignored. Changes to the request, active and spare inputs after the accepted start do not alter the table that is written.
- R8: The admitted slot count for bandwidth b is 0 when b is 0. Otherwise it is 64 divided by (peak / b), with both divisions being integer divisions. A bandwidth above the peak gives 64.
- R9: The admission reject flag is high exactly when the already-assigned total plus the new slot count exceeds 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Build request pulse, taken only when idle |
| free_slots_i | input | 7 | Spare slots available to zero-request clients |
| req_cnt_i | input | 98 | Per-client requested slots, client c at bits [7c+6:7c] |
| active_i | input | 14 | Per-client active flags |
| wr_en_o | output | 1 | Slot table write strobe |
| wr_idx_o | output | 6 | Slot index being written |
| wr_cli_o | output | 4 | Client index written into the slot |
| done_o | output | 1 | Build complete, held until next start |
| adm_bw_i | input | 32 | Bandwidth asked for by a new client |
| adm_assigned_i | input | 7 | Slots already granted in the region |
| adm_slots_o | output | 7 | Slot count for the asked bandwidth |
| adm_reject_o | output | 1 | The new count does not fit |

## Verification
Strides that do not divide 64 evenly, such as 64/3, push the probe onto occupied slots. A design that lands on the slot without skipping, or that restarts the stride after a skip, will overwrite earlier owners or lose slots. A spare count smaller than the number of active zero-request clients shows whether spares run out in client order. A no-active-client build shows whether the round-robin search falls back to the raw pointer; a design that falls back to client 0 instead will fill the leftovers with zeros. A second start pulse with scrambled inputs in the middle of a build exposes a design that restarts, or that reads its inputs live instead of from the snapshot. Bandwidths above the peak and counts that exactly reach 64 probe the admission divide and the reject threshold.

// File: rtl/stb_pkg.sv
package stb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PROBE,
    ST_FILL,
    ST_FIN
  } stb_state_e;
endpackage

// File: rtl/stb_stride.sv
module stb_stride #(
  parameter int unsigned N_SLOTS = 64,
  parameter int unsigned CNT_W   = 7
) (
  input  logic [CNT_W-1:0] req_i,
  output logic [CNT_W-1:0] stride_o
);
  always_comb begin
    if (req_i == '0)                   stride_o = CNT_W'(N_SLOTS);  // single spare slot
    else if (32'(req_i) > N_SLOTS)     stride_o = CNT_W'(1);
    else                               stride_o = CNT_W'(N_SLOTS / 32'(req_i));
  end
endmodule

// File: rtl/stb_rr_pick.sv
module stb_rr_pick #(
  parameter int unsigned N_CLI = 14,
  parameter int unsigned CLI_W = 4
) (
  input  logic [N_CLI-1:0] act_i,
  input  logic [CLI_W-1:0] ptr_i,
  output logic [CLI_W-1:0] pick_o
);
  int idx;
  always_comb begin
    pick_o = ptr_i;  // nobody active: keep pointer
    idx    = 0;
    for (int k = N_CLI - 1; k >= 0; k--) begin
      idx = int'(ptr_i) + k;
      if (idx >= int'(N_CLI)) idx = idx - int'(N_CLI);
      if (act_i[idx]) pick_o = CLI_W'(idx);
    end
  end
endmodule

// File: rtl/stb_admit.sv
module stb_admit #(
  parameter int unsigned N_SLOTS = 64,
  parameter int unsigned BW_W    = 32,
  parameter int unsigned PEAK_BW = 400000,
  parameter int unsigned CNT_W   = 7
) (
  input  logic [BW_W-1:0]  bw_i,
  input  logic [CNT_W-1:0] assigned_i,
  output logic [CNT_W-1:0] slots_o,
  output logic             reject_o
);
  logic [BW_W-1:0] ratio;
  logic [CNT_W:0]  total;

  always_comb begin
    ratio = '0;
    if (bw_i != '0) ratio = BW_W'(PEAK_BW) / bw_i;
    if (bw_i == '0)       slots_o = '0;
    else if (ratio == '0) slots_o = CNT_W'(N_SLOTS);
    else                  slots_o = CNT_W'(BW_W'(N_SLOTS) / ratio);
    total    = {1'b0, assigned_i} + {1'b0, slots_o};
    reject_o = total > (CNT_W+1)'(N_SLOTS);
  end
endmodule

// File: rtl/slot_table_builder.sv
module slot_table_builder
  import stb_pkg::*;
#(
  parameter int unsigned N_SLOTS = 64,
  parameter int unsigned N_CLI   = 14,
  parameter int unsigned BW_W    = 32,
  parameter int unsigned PEAK_BW = 400000,
  localparam int unsigned SLOT_W = $clog2(N_SLOTS),
  localparam int unsigned CLI_W  = $clog2(N_CLI + 1),
  localparam int unsigned CNT_W  = $clog2(N_SLOTS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [CNT_W-1:0]       free_slots_i,
  input  logic [N_CLI*CNT_W-1:0] req_cnt_i,
  input  logic [N_CLI-1:0]       active_i,
  output logic                   wr_en_o,
  output logic [SLOT_W-1:0]      wr_idx_o,
  output logic [CLI_W-1:0]       wr_cli_o,
  output logic                   done_o,
  input  logic [BW_W-1:0]        adm_bw_i,
  input  logic [CNT_W-1:0]       adm_assigned_i,
  output logic [CNT_W-1:0]       adm_slots_o,
  output logic                   adm_reject_o
);
  localparam int unsigned POS_W = CNT_W + 1;
  localparam logic [CLI_W-1:0] EMPTY = '1;  // sentinel, above any client index
  localparam logic [CLI_W-1:0] LAST_CLI = CLI_W'(N_CLI - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);

  stb_state_e        state_q;
  logic [CNT_W-1:0]  req_q [N_CLI];
  logic [N_CLI-1:0]  act_q;
  logic [CNT_W-1:0]  free_q;
  logic [CNT_W-1:0]  stride_q;
  logic [CNT_W-1:0]  stride_w;
  logic [CLI_W-1:0]  cli_q;
  logic [CLI_W-1:0]  rr_q;
  logic [CLI_W-1:0]  rr_pick;
  logic [POS_W-1:0]  pos_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CLI_W-1:0]  tbl_q [N_SLOTS];
  logic [CNT_W-1:0]  cur_req;
  logic              wr_en_q, done_q;
  logic [SLOT_W-1:0] wr_idx_q;
  logic [CLI_W-1:0]  wr_cli_q;

  assign cur_req = req_q[cli_q];

  stb_stride #(.N_SLOTS(N_SLOTS), .CNT_W(CNT_W)) u_stride (
    .req_i   (cur_req),
    .stride_o(stride_w)
  );

  stb_rr_pick #(.N_CLI(N_CLI), .CLI_W(CLI_W)) u_rr (
    .act_i (act_q),
    .ptr_i (rr_q),
    .pick_o(rr_pick)
  );

  stb_admit #(.N_SLOTS(N_SLOTS), .BW_W(BW_W), .PEAK_BW(PEAK_BW), .CNT_W(CNT_W)) u_admit (
    .bw_i      (adm_bw_i),
    .assigned_i(adm_assigned_i),
    .slots_o   (adm_slots_o),
    .reject_o  (adm_reject_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      act_q    <= '0;
      free_q   <= '0;
      stride_q <= '0;
      cli_q    <= '0;
      rr_q     <= '0;
      pos_q    <= '0;
      slot_q   <= '0;
      wr_en_q  <= 1'b0;
      wr_idx_q <= '0;
      wr_cli_q <= '0;
      done_q   <= 1'b0;
      for (int c = 0; c < int'(N_CLI); c++) req_q[c] <= '0;
      for (int s = 0; s < int'(N_SLOTS); s++) tbl_q[s] <= EMPTY;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            for (int c = 0; c < int'(N_CLI); c++) req_q[c] <= req_cnt_i[c*CNT_W +: CNT_W];
            for (int s = 0; s < int'(N_SLOTS); s++) tbl_q[s] <= EMPTY;
            act_q   <= active_i;
            free_q  <= free_slots_i;
            cli_q   <= '0;
            done_q  <= 1'b0;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          pos_q    <= '0;
          stride_q <= stride_w;
          if (cur_req != '0) begin
            state_q <= ST_PROBE;
          end else if (act_q[cli_q] && free_q != '0) begin
            free_q  <= free_q - 1'b1;
            state_q <= ST_PROBE;
          end else if (cli_q == LAST_CLI) begin
            slot_q  <= '0;
            rr_q    <= '0;
            state_q <= ST_FILL;
          end else begin
            cli_q <= cli_q + 1'b1;
          end
        end
        ST_PROBE: begin
          if (pos_q >= POS_W'(N_SLOTS)) begin
            if (cli_q == LAST_CLI) begin
              slot_q  <= '0;
              rr_q    <= '0;
              state_q <= ST_FILL;
            end else begin
              cli_q   <= cli_q + 1'b1;
              state_q <= ST_SETUP;
            end
          end else if (tbl_q[pos_q[SLOT_W-1:0]] != EMPTY) begin
            pos_q <= pos_q + 1'b1;
          end else begin
            tbl_q[pos_q[SLOT_W-1:0]] <= cli_q;
            pos_q <= pos_q + POS_W'(stride_q);
          end
        end
        ST_FILL: begin
          wr_en_q  <= 1'b1;
          wr_idx_q <= slot_q;
          if (tbl_q[slot_q] == EMPTY) begin
            wr_cli_q <= rr_pick;
            rr_q     <= (rr_pick == LAST_CLI) ? '0 : rr_pick + 1'b1;
          end else begin
            wr_cli_q <= tbl_q[slot_q];
          end
          if (slot_q == LAST_SLOT) state_q <= ST_FIN;
          else                     slot_q  <= slot_q + 1'b1;
        end
        ST_FIN: begin
          wr_en_q <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_en_o  = wr_en_q;
  assign wr_idx_o = wr_idx_q;
  assign wr_cli_o = wr_cli_q;
  assign done_o   = done_q;
endmodule

// File: rtl/stb_checker.sv
module stb_checker #(
  parameter int unsigned N_SLOTS = 64,
  parameter int unsigned N_CLI   = 14,
  localparam int unsigned SLOT_W = $clog2(N_SLOTS),
  localparam int unsigned CLI_W  = $clog2(N_CLI + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              wr_en_o,
  input logic [SLOT_W-1:0] wr_idx_o,
  input logic [CLI_W-1:0]  wr_cli_o,
  input logic              done_o
);
  a_r2_first_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> wr_idx_o == '0);

  a_r2_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> wr_idx_o == SLOT_W'($past(wr_idx_o) + 1'b1));

  a_r2_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_idx_o != SLOT_W'(N_SLOTS - 1)) |=> wr_en_o);

  a_r2_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(wr_en_o) && $past(wr_idx_o) == SLOT_W'(N_SLOTS - 1)));

  a_r2_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && wr_en_o));

  a_r5_client_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_cli_o < CLI_W'(N_CLI));

  a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && start_i && wr_idx_o != SLOT_W'(N_SLOTS - 1)) |=> (wr_en_o && !done_o));
endmodule

bind slot_table_builder stb_checker #(.N_SLOTS(N_SLOTS), .N_CLI(N_CLI)) u_stb_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .wr_en_o (wr_en_o),
  .wr_idx_o(wr_idx_o),
  .wr_cli_o(wr_cli_o),
  .done_o  (done_o)
);

// File: tb/tb_slot_table_builder.sv
module tb_slot_table_builder;
  localparam int NS = 64, NC = 14, KW = 7, BW = 32, PEAK = 400000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start = 1'b0;
  logic [KW-1:0] free_slots = '0;
  logic [NC*KW-1:0] req_flat = '0;
  logic [NC-1:0] act_v = '0;
  logic          wr_en, done;
  logic [5:0]    wr_idx;
  logic [3:0]    wr_cli;
  logic [BW-1:0] adm_bw = '0;
  logic [KW-1:0] adm_assigned = '0;
  logic [KW-1:0] adm_slots;
  logic          adm_reject;

  int n_chk = 0, n_err = 0;
  int got[NS];

  slot_table_builder #(.PEAK_BW(PEAK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .free_slots_i(free_slots),
    .req_cnt_i(req_flat), .active_i(act_v), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_cli_o(wr_cli), .done_o(done), .adm_bw_i(adm_bw), .adm_assigned_i(adm_assigned),
    .adm_slots_o(adm_slots), .adm_reject_o(adm_reject)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model(input int rq[NC], input bit ac[NC], input int fr, output int t[NS]);
    int f, st, p, rr, first;
    f = fr;
    for (int s = 0; s < NS; s++) t[s] = -1;
    for (int c = 0; c < NC; c++) begin
      if (rq[c] != 0) st = NS / rq[c];
      else begin
        if (!ac[c] || f <= 0) continue;
        f--;
        st = NS;
      end
      p = 0;
      while (p < NS) begin
        if (t[p] >= 0) p++;
        else begin t[p] = c; p += st; end
      end
    end
    rr = 0;
    for (int s = 0; s < NS; s++) begin
      if (t[s] < 0) begin
        first = rr;
        while (!ac[rr]) begin
          rr = (rr + 1) % NC;
          if (rr == first) break;
        end
        t[s] = rr;
        rr = (rr + 1) % NC;
      end
    end
  endtask

  function automatic int exp_slots(int bw);
    int q;
    if (bw == 0) return 0;
    q = PEAK / bw;
    if (q == 0) return NS;
    return NS / q;
  endfunction

  task automatic drive_inputs(input int rq[NC], input bit ac[NC], input int fr);
    for (int c = 0; c < NC; c++) begin
      req_flat[c*KW +: KW] = KW'(rq[c]);
      act_v[c] = ac[c];
    end
    free_slots = KW'(fr);
  endtask

  task automatic run_build(string tag, input int rq[NC], input bit ac[NC], input int fr, input bit disturb);
    int exp_t[NS];
    int wcnt, seqbad, cyc;
    bit prev_last, timed_out;
    model(rq, ac, fr, exp_t);
    for (int s = 0; s < NS; s++) got[s] = -1;
    @(negedge clk);
    drive_inputs(rq, ac, fr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wcnt = 0; seqbad = 0; cyc = 0; prev_last = 1'b0; timed_out = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (done) break;
      if (cyc > 5000) begin timed_out = 1'b1; break; end
      if (wr_en) begin
        if (int'(wr_idx) != wcnt) seqbad++;
        got[wr_idx] = int'(wr_cli);
        wcnt++;
        prev_last = (wr_idx == 6'd63);
      end else prev_last = 1'b0;
      if (disturb && cyc == 10) begin
        req_flat = {(NC*KW){1'b1}} ^ req_flat;
        act_v = ~act_v;
        free_slots = KW'(NS);
        start = 1'b1;
      end
      if (disturb && cyc == 11) start = 1'b0;
    end
    check("R2", {tag, " build finished"}, int'(timed_out), 0);
    check("R2", {tag, " write count"}, wcnt, NS);
    check("R2", {tag, " index order errors"}, seqbad, 0);
    check("R2", {tag, " done right after slot 63"}, int'(prev_last), 1);
    for (int s = 0; s < NS; s++) check(tag, $sformatf("slot %0d", s), got[s], exp_t[s]);
    repeat (3) @(negedge clk);
    check("R2", {tag, " done held"}, int'(done), 1);
    check("R2", {tag, " no write while done"}, int'(wr_en), 0);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int rq[NC];
    bit ac[NC];
    int seed_dummy, tot, v, b, bw;
    seed_dummy = $urandom(32'd20240);

    repeat (3) @(negedge clk);
    check("R1", "wr_en in reset", int'(wr_en), 0);
    check("R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "wr_en after reset", int'(wr_en), 0);
    check("R1", "done after reset", int'(done), 0);

    // R3: uneven stride forces skip-over probing
    for (int c = 0; c < NC; c++) begin rq[c] = 0; ac[c] = 1'b0; end
    rq[2] = 4; ac[2] = 1'b1; rq[5] = 3; ac[5] = 1'b1; rq[7] = 5; ac[7] = 1'b1;
    run_build("R3", rq, ac, 52, 1'b0);

    // R4: fewer spares than active zero-request clients
    for (int c = 0; c < NC; c++) begin rq[c] = 0; ac[c] = 1'b0; end
    rq[0] = 8; ac[0] = 1'b1; ac[1] = 1'b1; ac[4] = 1'b1; ac[9] = 1'b1; ac[13] = 1'b1;
    run_build("R4", rq, ac, 2, 1'b0);

    // R4: zero spares, zero-request clients only get leftovers
    run_build("R4", rq, ac, 0, 1'b0);

    // R6: nobody active, leftovers follow the raw pointer
    for (int c = 0; c < NC; c++) begin rq[c] = 0; ac[c] = 1'b0; end
    run_build("R6", rq, ac, 64, 1'b0);

    // R3: one client owns the whole table
    for (int c = 0; c < NC; c++) begin rq[c] = 0; ac[c] = 1'b0; end
    rq[11] = 64; ac[11] = 1'b1;
    run_build("R3", rq, ac, 0, 1'b0);

    // R7: second start and scrambled inputs during a build
    for (int c = 0; c < NC; c++) begin rq[c] = 0; ac[c] = (c % 3 == 0); end
    rq[3] = 6; ac[3] = 1'b1;
    run_build("R7", rq, ac, 4, 1'b1);

    // R5: random mixes
    for (int it = 0; it < 20; it++) begin
      tot = 0;
      for (int c = 0; c < NC; c++) begin
        rq[c] = 0;
        if ($urandom % 3 == 0) begin
          v = 1 + int'($urandom % 12);
          if (tot + v <= NS) begin rq[c] = v; tot += v; end
        end
        ac[c] = (rq[c] != 0) || ($urandom % 2 == 1);
      end
      b = (it % 4 == 0) ? int'($urandom % 4) : NS - tot;
      run_build("R5", rq, ac, b, 1'b0);
    end

    // R8 / R9: admission stage
    for (int k = 0; k < 12; k++) begin
      case (k)
        0: bw = 0;
        1: bw = 100000;
        2: bw = 6250;
        3: bw = 3000;
        4: bw = 500000;
        5: bw = 400000;
        default: bw = int'($urandom % 450000);
      endcase
      adm_bw = BW'(bw);
      adm_assigned = KW'(k == 1 ? 48 : (k == 4 ? 0 : int'($urandom % 65)));
      #1;
      check("R8", $sformatf("slots for bw %0d", bw), int'(adm_slots), exp_slots(bw));
      check("R9", $sformatf("reject bw %0d assigned %0d", bw, adm_assigned),
            int'(adm_reject), int'(int'(adm_assigned) + exp_slots(bw) > NS));
    end
    adm_bw = BW'(100000); adm_assigned = KW'(49); #1;
    check("R9", "reject just over 64", int'(adm_reject), 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule